// File: doc/BRIEF.md
# Radio Packet Transmit Buffer Controller

This block sits between a host register port and a downstream packet framer. The host programs a radio channel number, a packet length and a control byte through a small write-only register port. It pushes payload bytes into a 16-entry transmit store through a valid/ready stream. When the host sets the start bit, the framer pulls a stream that carries the length byte first and then the payload bytes in the order they were written. The framer closes the packet with a done pulse, which can carry an error indication.

Transmission may start before any payload has been written. Packets longer than the store are sent by writing more bytes while the framer drains it. The store keeps its bytes after a packet, so a packet of 16 bytes or fewer can be sent again by setting the start bit without clearing the store. Three level flags, three sticky event flags and six enable bits combine into a single interrupt line.

Both streams follow the usual rules. A beat moves on a clock edge where valid and ready are both high. The host's `wr_valid` is not gated by `wr_ready`. The block holds `fr_valid`, `fr_data` and `fr_is_len` steady while `fr_ready` is low. The framer may stall for any number of cycles.

Top module: `pkt_tx_buffer`

## Requirements
- R1: After reset the channel is 0x48, the length is 0, `busy_o`, `irq_o` and `fr_valid` are 0, `wr_ready` is 1, and `status_o` is 6'b111000.
- R2: A write to address 0 loads `reg_wdata[6:0]` into the channel when that value is at most 0x62. A larger value is ignored, and so is `reg_wdata[7]`.
- R3: While `busy_o` is 1, writes to the channel (address 0) and to the length (address 1) are ignored.
- R4: At address 2, bit 7 is start. Writing 1 while idle sets `busy_o` on the next cycle. Writing 0 has no effect. `busy_o` returns to 0 on the cycle after the framer's `fr_done` pulse.
- R5: At address 2, bit 6 is clear. Writing 1 while idle empties the store. Writing 0 leaves the store unchanged.
- R6: After a start, the first framer beat has `fr_is_len`=1 and carries the length. It is followed by exactly that many beats with `fr_is_len`=0, holding the payload in write order. A stalled beat holds its valid, data and flag.
- R7: `wr_ready` is 1 exactly when the store holds fewer than 16 bytes. Packets of up to 40 bytes are sent by writing the rest during transmission.
- R8: `status_o` bit 5 (not-full) means 15 or fewer bytes are held. Bit 4 (half-empty) means 8 or fewer. Bit 3 (empty) means 0. No payload beat is offered while the store is empty.
- R9: `status_o` bit 2 (buffer error) is set when the length beat is accepted with a nonzero length while the store is empty. It stays set until the next start.
- R10: `status_o` bit 1 (complete) is set by `fr_done`. Bit 0 (error) is set by `fr_done` together with `fr_err`. A start clears bits 2, 1 and 0.
- R11: Control bits 5..0 enable `status_o` bits 5..0 one for one. Every control write loads them. `irq_o` is the OR of each status bit ANDed with its enable.
- R12: Starting again without a clear resends the previous packet when 16 or fewer bytes were written since the last clear.
- R13: A length of 0 gives a single length beat and no payload beats, and it does not set the buffer error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 channel, 1 length, 2 control |
| reg_wdata | input | 8 | Register write data |
| wr_valid | input | 1 | Host payload byte valid |
| wr_data | input | 8 | Host payload byte |
| wr_ready | output | 1 | Store can accept a byte |
| fr_valid | output | 1 | Beat offered to the framer |
| fr_data | output | 8 | Length or payload byte |
| fr_is_len | output | 1 | Current beat is the length byte |
| fr_ready | input | 1 | Framer accepts the beat |
| fr_done | input | 1 | Framer ends the packet (one-cycle pulse) |
| fr_err | input | 1 | Packet ended with an error, qualified by fr_done |
| chan_o | output | 7 | Current channel |
| len_o | output | 8 | Current packet length |
| busy_o | output | 1 | Transmit in progress |
| status_o | output | 6 | Flags: not-full, half-empty, empty, buffer error, complete, error |
| irq_o | output | 1 | Interrupt |

## Verification
A wrong read or write pointer shows on the framer stream on the first payload beat after the fault, as a byte out of order or a missing byte. The scoreboard catches this on that same beat. A wrong occupancy count shows within one cycle as a mismatch between `wr_ready` and the level flags, or as a payload beat offered while the store is empty. A lost start or done shows as `busy_o` stuck or never set, and the complete flag missing on the cycle after `fr_done`. A faulty replay rewind shows as wrong bytes in the second copy of a packet.

// File: rtl/pkt_tx_pkg.sv
`timescale 1ns/1ps
package pkt_tx_pkg;
  localparam logic [1:0] ADDR_CHAN = 2'd0;
  localparam logic [1:0] ADDR_LEN  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int BIT_GO  = 7;
  localparam int BIT_CLR = 6;

  // status bit positions, matched one for one by control enables 5..0
  localparam int ST_NFULL = 5;
  localparam int ST_HALF  = 4;
  localparam int ST_EMPTY = 3;
  localparam int ST_BERR  = 2;
  localparam int ST_DONE  = 1;
  localparam int ST_ERR   = 0;
  localparam int ST_W     = 6;

  typedef enum logic {PH_LEN, PH_DATA} phase_e;
endpackage

// File: rtl/tx_byte_store.sv
`timescale 1ns/1ps
module tx_byte_store #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             rewind_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  output logic [CNT_W-1:0] occ_o,
  output logic [DW-1:0]    rd_data_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] wr_tot, rd_tot;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_tot[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_tot <= '0;
      rd_tot <= '0;
    end else if (clr_i) begin
      wr_tot <= '0;
      rd_tot <= '0;
    end else if (rewind_i) begin
      rd_tot <= '0;
      if (wr_tot > CNT_W'(DEPTH)) wr_tot <= '0;
      else                        wr_tot <= wr_tot + CNT_W'(wr_en_i);
    end else begin
      wr_tot <= wr_tot + CNT_W'(wr_en_i);
      rd_tot <= rd_tot + CNT_W'(rd_en_i);
    end
  end

  assign occ_o     = wr_tot - rd_tot;
  assign rd_data_o = mem[rd_tot[AW-1:0]];
endmodule

// File: rtl/tx_regs.sv
`timescale 1ns/1ps
module tx_regs
  import pkt_tx_pkg::*;
#(
  parameter logic [6:0] CHAN_MAX = 7'h62,
  parameter logic [6:0] CHAN_RST = 7'h48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [1:0]      addr_i,
  input  logic [7:0]      wdata_i,
  input  logic            busy_i,
  output logic [6:0]      chan_o,
  output logic [7:0]      len_o,
  output logic [ST_W-1:0] en_o,
  output logic            start_o,
  output logic            clear_o
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);
  assign start_o = ctrl_wr && wdata_i[BIT_GO]  && !busy_i;
  assign clear_o = ctrl_wr && wdata_i[BIT_CLR] && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_o <= CHAN_RST;
      len_o  <= '0;
      en_o   <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_CHAN && !busy_i && wdata_i[6:0] <= CHAN_MAX) chan_o <= wdata_i[6:0];
      if (addr_i == ADDR_LEN && !busy_i) len_o <= wdata_i;
      if (ctrl_wr) en_o <= wdata_i[ST_W-1:0];
    end
  end
endmodule

// File: rtl/tx_seq.sv
`timescale 1ns/1ps
module tx_seq
  import pkt_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             err_i,
  input  logic [7:0]       len_i,
  input  logic [CNT_W-1:0] occ_i,
  input  logic             ready_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic             is_len_o,
  output logic             rd_en_o,
  output logic             berr_o,
  output logic             done_o,
  output logic             err_o
);
  phase_e     phase;
  logic [7:0] sent;
  logic       fire, more_data;

  assign more_data = (sent < len_i) && (occ_i != '0);
  assign is_len_o  = busy_o && (phase == PH_LEN);
  assign valid_o   = busy_o && ((phase == PH_LEN) || more_data);
  assign fire      = valid_o && ready_i && !done_i;
  assign rd_en_o   = fire && (phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      phase  <= PH_LEN;
      sent   <= '0;
      berr_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      phase  <= PH_LEN;
      sent   <= '0;
      berr_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (busy_o) begin
      if (done_i) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        err_o  <= err_i;
      end else if (fire) begin
        if (phase == PH_LEN) begin
          phase <= PH_DATA;
          if (len_i != '0 && occ_i == '0) berr_o <= 1'b1;
        end else begin
          sent <= sent + 8'd1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_tx_buffer.sv
`timescale 1ns/1ps
module pkt_tx_buffer
  import pkt_tx_pkg::*;
#(
  parameter int         DEPTH    = 16,
  parameter int         CNT_W    = 8,
  parameter logic [6:0] CHAN_MAX = 7'h62,
  parameter logic [6:0] CHAN_RST = 7'h48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  input  logic            wr_valid,
  input  logic [7:0]      wr_data,
  output logic            wr_ready,
  output logic            fr_valid,
  output logic [7:0]      fr_data,
  output logic            fr_is_len,
  input  logic            fr_ready,
  input  logic            fr_done,
  input  logic            fr_err,
  output logic [6:0]      chan_o,
  output logic [7:0]      len_o,
  output logic            busy_o,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o
);
  localparam int HALF = DEPTH / 2;

  logic [ST_W-1:0]  en;
  logic             start, clear, rd_en, berr, done_f, err_f;
  logic [CNT_W-1:0] occ;
  logic [7:0]       rd_data;

  tx_regs #(.CHAN_MAX(CHAN_MAX), .CHAN_RST(CHAN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .busy_i(busy_o), .chan_o(chan_o), .len_o(len_o), .en_o(en),
    .start_o(start), .clear_o(clear)
  );

  tx_byte_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DW(8)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_i(clear), .rewind_i(start),
    .wr_en_i(wr_valid && wr_ready), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .occ_o(occ), .rd_data_o(rd_data)
  );

  tx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .done_i(fr_done), .err_i(fr_err),
    .len_i(len_o), .occ_i(occ), .ready_i(fr_ready), .busy_o(busy_o),
    .valid_o(fr_valid), .is_len_o(fr_is_len), .rd_en_o(rd_en),
    .berr_o(berr), .done_o(done_f), .err_o(err_f)
  );

  assign wr_ready = occ < CNT_W'(DEPTH);
  assign fr_data  = fr_is_len ? len_o : rd_data;

  always_comb begin
    status_o           = '0;
    status_o[ST_NFULL] = occ < CNT_W'(DEPTH);
    status_o[ST_HALF]  = occ <= CNT_W'(HALF);
    status_o[ST_EMPTY] = occ == '0;
    status_o[ST_BERR]  = berr;
    status_o[ST_DONE]  = done_f;
    status_o[ST_ERR]   = err_f;
  end

  assign irq_o = |(status_o & en);
endmodule

// File: rtl/pkt_tx_buffer_chk.sv
`timescale 1ns/1ps
module pkt_tx_buffer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic [6:0] chan_o,
  input logic [7:0] len_o,
  input logic       fr_valid,
  input logic [7:0] fr_data,
  input logic       fr_is_len,
  input logic       fr_ready,
  input logic       fr_done,
  input logic       fr_err,
  input logic [5:0] status_o
);
  assert_len_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(len_o));

  assert_chan_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(chan_o));

  assert_chan_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_o <= 7'h62);

  assert_first_beat_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (fr_valid && fr_is_len));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_ready && !fr_done) |=> (fr_valid && $stable(fr_data) && $stable(fr_is_len)));

  assert_no_beat_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[3] |-> !(fr_valid && !fr_is_len));

  assert_full_not_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[5] |-> !status_o[4]);

  assert_berr_on_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_ready && fr_is_len && len_o != 8'd0 && status_o[3] && !fr_done) |=> status_o[2]);

  assert_done_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> status_o[1]);

  assert_err_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && $past(fr_err)) |-> status_o[0]);
endmodule

bind pkt_tx_buffer pkt_tx_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .chan_o(chan_o), .len_o(len_o),
  .fr_valid(fr_valid), .fr_data(fr_data), .fr_is_len(fr_is_len), .fr_ready(fr_ready),
  .fr_done(fr_done), .fr_err(fr_err), .status_o(status_o)
);

// File: tb/tb_pkt_tx_buffer.sv
`timescale 1ns/1ps
module tb_pkt_tx_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       fr_valid, fr_is_len;
  logic [7:0] fr_data;
  logic       fr_ready = 1'b0;
  logic       fr_done = 1'b0;
  logic       fr_err = 1'b0;
  logic [6:0] chan_o;
  logic [7:0] len_o;
  logic       busy_o, irq_o;
  logic [5:0] status_o;

  always #2 clk = ~clk;

  pkt_tx_buffer dut (.*);

  int          n_chk = 0, n_err = 0, beats = 0;
  logic [8:0]  exp_q[$];
  logic [7:0]  model[64];
  int          model_n = 0;
  string       cur_req = "R6";
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // monitor: compares every accepted framer beat with the scoreboard
  always @(negedge clk) begin
    if (rst_n && fr_valid && fr_ready) begin
      beats++;
      if (exp_q.size() == 0)
        check(1'b0, cur_req, "unexpected beat", {fr_is_len, fr_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({fr_is_len, fr_data} == e, cur_req, "beat", {fr_is_len, fr_data}, e);
      end
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    forever begin
      @(negedge clk);
      if (wr_ready) break;
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
    model[model_n] = d;
    model_n++;
  endtask

  task automatic expect_pkt(input int len, input string req);
    cur_req = req;
    exp_q.push_back({1'b1, 8'(len)});
    for (int i = 0; i < len; i++) exp_q.push_back({1'b0, model[i]});
  endtask

  task automatic framer(input int target, input bit stall, input bit err);
    int b0, k;
    b0 = beats; k = 0;
    fr_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (beats - b0 >= target) break;
      k++;
      fr_ready = !(stall && (k % 3 == 0));
    end
    fr_ready = 1'b0; fr_done = 1'b1; fr_err = err;
    @(posedge clk); #1;
    fr_done = 1'b0; fr_err = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "ALL", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check(chan_o == 7'h48, "R1", "chan", chan_o, 'h48);
    check(len_o == 8'd0 && !busy_o && !irq_o && !fr_valid, "R1", "len/busy/irq/valid", {len_o, busy_o, irq_o, fr_valid}, 0);
    check(wr_ready && status_o == 6'b111000, "R1", "ready/status", {wr_ready, status_o}, 'h78);

    // R2 channel range
    reg_wr(2'd0, 8'h62);
    check(chan_o == 7'h62, "R2", "chan max", chan_o, 'h62);
    reg_wr(2'd0, 8'h63);
    check(chan_o == 7'h62, "R2", "chan invalid kept", chan_o, 'h62);
    reg_wr(2'd0, 8'h85);
    check(chan_o == 7'h05, "R2", "chan bit7 ignored", chan_o, 'h05);

    // R4 writing 0 to start does nothing
    reg_wr(2'd2, 8'h00);
    @(posedge clk); #1;
    check(!busy_o && !fr_valid, "R4", "zero start", {busy_o, fr_valid}, 0);

    // R8 levels, R5 clear
    for (int i = 0; i < 8; i++) host_wr(8'hA0 + 8'(i));
    check(status_o == 6'b110000, "R8", "8 bytes", status_o, 'h30);
    host_wr(8'hA8);
    check(status_o == 6'b100000, "R8", "9 bytes", status_o, 'h20);
    reg_wr(2'd2, 8'h00);
    check(status_o == 6'b100000, "R5", "clear bit 0 keeps", status_o, 'h20);
    reg_wr(2'd2, 8'h40);
    model_n = 0;
    check(status_o == 6'b111000 && wr_ready, "R5", "cleared", status_o, 'h38);

    // R6 normal packet with framer stalls, R3 writes ignored while busy
    for (int i = 0; i < 5; i++) host_wr(8'h10 + 8'(i));
    reg_wr(2'd1, 8'd5);
    expect_pkt(5, "R6");
    reg_wr(2'd2, 8'h80);
    check(busy_o, "R4", "start sets busy", busy_o, 1);
    reg_wr(2'd1, 8'd9);
    reg_wr(2'd0, 8'h11);
    check(len_o == 8'd5 && chan_o == 7'h05, "R3", "len/chan frozen", {len_o, 1'b0, chan_o}, 'h0505);
    framer(6, 1'b1, 1'b0);
    check(!busy_o, "R4", "busy clears after done", busy_o, 0);
    check(status_o == 6'b111010, "R10", "complete flag", status_o, 'h3a);

    // R12 replay without clear, ending with error
    expect_pkt(5, "R12");
    reg_wr(2'd2, 8'h80);
    check(status_o[1] == 1'b0, "R10", "start clears complete", status_o, 'h38);
    framer(6, 1'b0, 1'b1);
    check(status_o == 6'b111011, "R10", "error flag", status_o, 'h3b);

    // R13 zero length
    reg_wr(2'd2, 8'h40);
    model_n = 0;
    reg_wr(2'd1, 8'd0);
    expect_pkt(0, "R13");
    reg_wr(2'd2, 8'h80);
    check(status_o[2:0] == 3'b000, "R10", "sticky cleared", status_o, 'h38);
    framer(1, 1'b0, 1'b0);
    check(status_o[2] == 1'b0 && status_o[1], "R13", "no berr on zero length", status_o, 'h3a);

    // R9 start before data: buffer error, then late bytes still flow
    reg_wr(2'd1, 8'd3);
    cur_req = "R9";
    exp_q.push_back({1'b1, 8'd3});
    for (int i = 0; i < 3; i++) exp_q.push_back({1'b0, 8'h30 + 8'(i)});
    reg_wr(2'd2, 8'h80);
    fork
      framer(4, 1'b0, 1'b0);
      begin
        repeat (6) @(posedge clk);
        #1;
        check(status_o[2], "R9", "buffer error", status_o, 'h0c);
        check(!fr_valid, "R8", "no beat when empty", fr_valid, 0);
        for (int i = 0; i < 3; i++) host_wr(8'h30 + 8'(i));
      end
    join
    check(status_o[2] && status_o[1], "R9", "berr sticky after done", status_o, 'h3e);

    // R7 40-byte packet streamed through the 16-byte store
    reg_wr(2'd2, 8'h40);
    model_n = 0;
    for (int i = 0; i < 16; i++) host_wr(8'(i * 7 + 3));
    check(!wr_ready && !status_o[5], "R7", "full blocks writes", {wr_ready, status_o[5]}, 0);
    reg_wr(2'd1, 8'd40);
    cur_req = "R7";
    exp_q.push_back({1'b1, 8'd40});
    for (int i = 0; i < 40; i++) exp_q.push_back({1'b0, 8'(i * 7 + 3)});
    reg_wr(2'd2, 8'h80);
    fork
      framer(41, 1'b1, 1'b0);
      for (int j = 16; j < 40; j++) host_wr(8'(j * 7 + 3));
    join
    check(!busy_o && status_o == 6'b111010, "R7", "long packet done", status_o, 'h3a);
    check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);

    // R11 interrupt gating
    check(!irq_o, "R11", "no enables", irq_o, 0);
    reg_wr(2'd2, 8'h02);
    check(irq_o, "R11", "complete enabled", irq_o, 1);
    reg_wr(2'd2, 8'h04);
    check(!irq_o, "R11", "berr enabled but clear", irq_o, 0);
    reg_wr(2'd2, 8'h08);
    check(irq_o, "R11", "empty enabled", irq_o, 1);
    host_wr(8'h5A);
    check(!irq_o, "R11", "empty gone", irq_o, 0);
    reg_wr(2'd2, 8'h20);
    check(irq_o, "R11", "not-full enabled", irq_o, 1);

    summary();
  end
endmodule